// File: doc/BRIEF.md
# Reservation Station Group with Broadcast Result Bus

This block holds the waiting instructions of one functional-unit class in a dynamically scheduled datapath. Instructions arrive in program order from an instruction queue. At acceptance each source register is renamed: it becomes either a value read from the register file or the tag of the station that will produce it. A table with one producer tag per register records which station will write each register. Because later readers wait on tags rather than register names, write-after-read and write-after-write conflicts never stall issue.

Waiting stations watch a shared result bus that carries a data word and the tag of the station that produced it. A station whose pending tag matches copies the data. A station whose operands are both present offers itself to the execution unit, and the oldest ready station wins. The execution unit's result is sent back through a one-producer bus request/grant pair. When a result carrying a station's tag is seen on the bus, that station is released. The register file is written only if the register's producer tag still names that broadcast.

Tags are `TAG_BASE + i` for station `i`. Tag 0 means "no producer". The issue and dispatch interfaces are valid/ready. A transfer happens on a clock edge where both are high. The block withdraws `ex_valid` only after a transfer. The execution unit must hold `res_valid`, `res_tag` and `res_data` steady until `bus_grant` is seen.

Top module: `rs_station_unit`

## Requirements
- R1: After reset all stations are free, `iq_ready` is 1, and `ex_valid`, `rf_wr_en` and `bus_req` are 0.
- R2: An instruction is accepted when `iq_valid` and `iq_ready` are both high, into the lowest-numbered free station. `iq_ready` is 0 while every station is busy, and an instruction offered then changes no station and no producer tag.
- R3: At acceptance, a used source whose register has producer tag 0 takes the register-file value and tag 0. A used source with a pending producer takes that producer's tag. An unused source (`iq_use_j`/`iq_use_k` = 0) gets value 0 and tag 0.
- R4: Acceptance sets the destination register's producer tag to the new station's tag, replacing any older producer of the same register.
- R5: On a bus cycle (`cdb_valid`=1), every busy station whose pending tag equals `cdb_tag` stores `cdb_data` for that operand and clears the tag.
- R6: If the result bus carries the pending producer of a source in the same cycle the instruction is accepted, the station receives the bus data directly and the operand is ready.
- R7: A station is offered on `ex_valid` only when both operand tags are 0 and it has not been dispatched. An offer is held until `ex_ready`, and a dispatched station is not offered again.
- R8: Among ready stations, the one accepted earliest is offered first, whatever the station numbers are.
- R9: During a bus cycle, `rf_wr_en` is 1 with the matching register index and `cdb_data` exactly when some register's producer tag equals `cdb_tag`. That register's producer tag then returns to 0. A register whose producer tag has moved on is not written.
- R10: A bus cycle carrying station `i`'s tag releases station `i`, which becomes free on the next cycle.
- R11: `bus_req` follows `res_valid`, and `bus_tag`/`bus_data` carry the result. `res_ready` is high only while `bus_grant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_valid | input | 1 | Instruction offered by the queue |
| iq_ready | output | 1 | A station is free |
| iq_op | input | OP_W | Operation code, carried to the unit |
| iq_dst | input | REG_W | Destination register |
| iq_src_j | input | REG_W | First source register |
| iq_src_k | input | REG_W | Second source register |
| iq_use_j | input | 1 | First source is needed |
| iq_use_k | input | 1 | Second source is needed |
| iq_addr | input | ADDR_W | Immediate / address field |
| rf_rd_j_idx | output | REG_W | Register-file read index, first source |
| rf_rd_k_idx | output | REG_W | Register-file read index, second source |
| rf_rd_j_data | input | DATA_W | Register-file read data, first source (same cycle) |
| rf_rd_k_data | input | DATA_W | Register-file read data, second source (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | REG_W | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| ex_valid | output | 1 | A ready station is offered |
| ex_ready | input | 1 | Execution unit takes the offer |
| ex_op | output | OP_W | Operation of offered station |
| ex_vj | output | DATA_W | First operand |
| ex_vk | output | DATA_W | Second operand |
| ex_addr | output | ADDR_W | Address field |
| ex_tag | output | TAG_W | Tag of offered station |
| res_valid | input | 1 | Execution unit has a result |
| res_ready | output | 1 | Result is being broadcast |
| res_tag | input | TAG_W | Tag of the result's station |
| res_data | input | DATA_W | Result value |
| bus_req | output | 1 | Request for the result bus |
| bus_grant | input | 1 | Result bus granted to this unit |
| bus_tag | output | TAG_W | Tag driven toward the bus |
| bus_data | output | DATA_W | Data driven toward the bus |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Producer tag on the bus |
| cdb_data | input | DATA_W | Data on the bus |

## Verification
A stale or wrong producer tag shows up at the ports within one bus cycle. It either writes the register file when it should not, or it leaves a dependent station off `ex_valid` forever. A station that missed a capture shows a wrong `ex_vj`/`ex_vk` on the first offer after the broadcast. A corrupted age order shows up as the wrong `ex_tag` as soon as two stations are ready together. The bench therefore checks the offered tag and operands after every accept, broadcast and dispatch. It also checks the write port during each bus cycle, including a broadcast that arrives in the same cycle as an issue.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Life of one station: empty, holding an instruction, handed to the unit.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SENT = 2'd2
  } slot_phase_e;
endpackage

// File: rtl/rs_first_free.sv
module rs_first_free #(
  parameter int N = 4
) (
  input  logic [N-1:0] avail,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (avail[i]) pick = N'(1) << i;
    end
  end
  assign any = |avail;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // elder[a][b] = 1 when entry a was filled before entry b
  logic [N-1:0] elder [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < N; a++) elder[a] <= '0;
    end else begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          if (alloc[a]) elder[a][b] <= 1'b0;
          else if (alloc[b]) elder[a][b] <= 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_sel
    logic [N-1:0] beaten;
    always_comb begin
      for (int a = 0; a < N; a++) beaten[a] = req[a] & elder[a][b];
    end
    assign gnt[b] = req[b] & ~(|beaten);
  end

  assign any = |req;
endmodule

// File: rtl/rs_rename.sv
module rs_rename #(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              use_j,
  input  logic              use_k,
  input  logic [REG_W-1:0]  src_j,
  input  logic [REG_W-1:0]  src_k,
  input  logic [DATA_W-1:0] rf_j,
  input  logic [DATA_W-1:0] rf_k,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [TAG_W-1:0]  opj_tag,
  output logic [DATA_W-1:0] opj_val,
  output logic [TAG_W-1:0]  opk_tag,
  output logic [DATA_W-1:0] opk_val,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  logic [TAG_W-1:0] owner [NUM_REGS];
  logic             bus_live;

  assign bus_live = cdb_valid && (cdb_tag != '0);

  // Turn a source register into {tag, value}; a same-cycle broadcast wins.
  function automatic logic [TAG_W+DATA_W-1:0] resolve(
    input logic needed, input logic [REG_W-1:0] idx, input logic [DATA_W-1:0] rf_val);
    logic [TAG_W-1:0] pend;
    pend = owner[idx];
    if (!needed)                          return '0;
    else if (pend == '0)                  return {{TAG_W{1'b0}}, rf_val};
    else if (bus_live && cdb_tag == pend) return {{TAG_W{1'b0}}, cdb_data};
    else                                  return {pend, {DATA_W{1'b0}}};
  endfunction

  assign {opj_tag, opj_val} = resolve(use_j, src_j, rf_j);
  assign {opk_tag, opk_val} = resolve(use_k, src_k, rf_k);

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (bus_live && owner[r] == cdb_tag) begin
        wr_en  = 1'b1;
        wr_idx = REG_W'(r);
      end
    end
  end
  assign wr_data = cdb_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (alloc_fire && alloc_dst == REG_W'(r)) owner[r] <= alloc_tag;
        else if (bus_live && owner[r] == cdb_tag) owner[r] <= '0;
      end
    end
  end
endmodule

// File: rtl/rs_station_unit.sv
module rs_station_unit #(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 16,
  parameter int TAG_BASE = 1,
  parameter int OP_W     = 4,
  parameter int ADDR_W   = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iq_valid,
  output logic              iq_ready,
  input  logic [OP_W-1:0]   iq_op,
  input  logic [REG_W-1:0]  iq_dst,
  input  logic [REG_W-1:0]  iq_src_j,
  input  logic [REG_W-1:0]  iq_src_k,
  input  logic              iq_use_j,
  input  logic              iq_use_k,
  input  logic [ADDR_W-1:0] iq_addr,
  output logic [REG_W-1:0]  rf_rd_j_idx,
  output logic [REG_W-1:0]  rf_rd_k_idx,
  input  logic [DATA_W-1:0] rf_rd_j_data,
  input  logic [DATA_W-1:0] rf_rd_k_data,
  output logic              rf_wr_en,
  output logic [REG_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_vj,
  output logic [DATA_W-1:0] ex_vk,
  output logic [ADDR_W-1:0] ex_addr,
  output logic [TAG_W-1:0]  ex_tag,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [TAG_W-1:0]  bus_tag,
  output logic [DATA_W-1:0] bus_data,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  import rs_pkg::*;

  slot_phase_e       phase   [NUM_RS];
  logic [OP_W-1:0]   st_op   [NUM_RS];
  logic [DATA_W-1:0] st_vj   [NUM_RS];
  logic [DATA_W-1:0] st_vk   [NUM_RS];
  logic [TAG_W-1:0]  st_qj   [NUM_RS];
  logic [TAG_W-1:0]  st_qk   [NUM_RS];
  logic [ADDR_W-1:0] st_addr [NUM_RS];

  logic [NUM_RS-1:0] busy_vec, free_vec, ready_vec, alloc_vec, pick_vec, gnt_vec, own_hit;
  logic              any_free, iq_fire, ex_fire;
  logic [TAG_W-1:0]  alloc_tag, nj_tag, nk_tag;
  logic [DATA_W-1:0] nj_val, nk_val;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_flags
    assign busy_vec[i]  = (phase[i] != SLOT_FREE);
    assign free_vec[i]  = ~busy_vec[i];
    assign ready_vec[i] = (phase[i] == SLOT_WAIT) && (st_qj[i] == '0) && (st_qk[i] == '0);
    assign own_hit[i]   = cdb_valid && (cdb_tag == TAG_W'(TAG_BASE + i));
  end

  rs_first_free #(.N(NUM_RS)) free_pick_i (
    .avail(free_vec), .pick(pick_vec), .any(any_free));

  assign iq_ready  = any_free;
  assign iq_fire   = iq_valid && any_free;
  assign alloc_vec = iq_fire ? pick_vec : '0;

  always_comb begin
    alloc_tag = '0;
    for (int i = 0; i < NUM_RS; i++)
      if (pick_vec[i]) alloc_tag = TAG_W'(TAG_BASE + i);
  end

  assign rf_rd_j_idx = iq_src_j;
  assign rf_rd_k_idx = iq_src_k;

  rs_rename #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) rename_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(iq_fire), .alloc_dst(iq_dst), .alloc_tag(alloc_tag),
    .use_j(iq_use_j), .use_k(iq_use_k), .src_j(iq_src_j), .src_k(iq_src_k),
    .rf_j(rf_rd_j_data), .rf_k(rf_rd_k_data),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .opj_tag(nj_tag), .opj_val(nj_val), .opk_tag(nk_tag), .opk_val(nk_val),
    .wr_en(rf_wr_en), .wr_idx(rf_wr_idx), .wr_data(rf_wr_data));

  rs_age_pick #(.N(NUM_RS)) age_i (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_vec), .req(ready_vec),
    .gnt(gnt_vec), .any(ex_valid));

  assign ex_fire = ex_valid && ex_ready;

  always_comb begin
    ex_op = '0; ex_vj = '0; ex_vk = '0; ex_addr = '0; ex_tag = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (gnt_vec[i]) begin
        ex_op   = st_op[i];
        ex_vj   = st_vj[i];
        ex_vk   = st_vk[i];
        ex_addr = st_addr[i];
        ex_tag  = TAG_W'(TAG_BASE + i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RS; i++) begin
        phase[i] <= SLOT_FREE;
        st_op[i] <= '0; st_vj[i] <= '0; st_vk[i] <= '0;
        st_qj[i] <= '0; st_qk[i] <= '0; st_addr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (own_hit[i] && busy_vec[i]) begin
          phase[i] <= SLOT_FREE;
        end else if (alloc_vec[i]) begin
          phase[i]   <= SLOT_WAIT;
          st_op[i]   <= iq_op;
          st_addr[i] <= iq_addr;
          st_qj[i]   <= nj_tag;
          st_vj[i]   <= nj_val;
          st_qk[i]   <= nk_tag;
          st_vk[i]   <= nk_val;
        end else if (busy_vec[i]) begin
          if (cdb_valid && st_qj[i] != '0 && st_qj[i] == cdb_tag) begin
            st_vj[i] <= cdb_data;
            st_qj[i] <= '0;
          end
          if (cdb_valid && st_qk[i] != '0 && st_qk[i] == cdb_tag) begin
            st_vk[i] <= cdb_data;
            st_qk[i] <= '0;
          end
          if (ex_fire && gnt_vec[i]) phase[i] <= SLOT_SENT;
        end
      end
    end
  end

  // Single-producer side of the result bus.
  assign bus_req   = res_valid;
  assign bus_tag   = res_tag;
  assign bus_data  = res_data;
  assign res_ready = bus_grant;
endmodule

// File: rtl/rs_station_unit_chk.sv
module rs_station_unit_chk #(
  parameter int NUM_RS   = 4,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iq_valid,
  input logic              iq_ready,
  input logic              ex_valid,
  input logic              ex_ready,
  input logic [TAG_W-1:0]  ex_tag,
  input logic              rf_wr_en,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [NUM_RS-1:0] busy_vec
);
  logic [NUM_RS-1:0] tag_hit;
  for (genvar i = 0; i < NUM_RS; i++) begin : g_hit
    assign tag_hit[i] = cdb_valid && (cdb_tag == TAG_W'(TAG_BASE + i));
  end

  // R9
  rf_write_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> cdb_valid);

  // R7
  offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |=> ex_valid);

  // R7
  no_double_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_ready |=> !ex_valid || (ex_tag != $past(ex_tag)));

  // R2
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid && !iq_ready |=> $countones(busy_vec) <= $countones($past(busy_vec)));

  // R10
  release_on_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_hit & busy_vec) != '0 |=> (busy_vec & $past(tag_hit)) == '0);
endmodule

bind rs_station_unit rs_station_unit_chk #(
  .NUM_RS(NUM_RS), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) chk_i (.*);

// File: tb/rs_station_unit_tb.sv
module rs_station_unit_tb_top;
  localparam int DW = 64;
  localparam int TW = 4;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic iq_valid = 0, iq_ready, iq_use_j = 0, iq_use_k = 0;
  logic [3:0] iq_op = 0;
  logic [RW-1:0] iq_dst = 0, iq_src_j = 0, iq_src_k = 0;
  logic [15:0] iq_addr = 0;
  logic [RW-1:0] rf_rd_j_idx, rf_rd_k_idx, rf_wr_idx;
  logic [DW-1:0] rf_rd_j_data, rf_rd_k_data, rf_wr_data;
  logic rf_wr_en;
  logic ex_valid, ex_ready = 0;
  logic [3:0] ex_op;
  logic [DW-1:0] ex_vj, ex_vk;
  logic [15:0] ex_addr;
  logic [TW-1:0] ex_tag;
  logic res_valid = 0, res_ready, bus_req, bus_grant = 0;
  logic [TW-1:0] res_tag = 0, bus_tag, cdb_tag;
  logic [DW-1:0] res_data = 0, bus_data, cdb_data;
  logic cdb_valid;

  logic [DW-1:0] rf [16];
  assign rf_rd_j_data = rf[rf_rd_j_idx];
  assign rf_rd_k_data = rf[rf_rd_k_idx];
  always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

  assign cdb_valid = bus_req & bus_grant;
  assign cdb_tag   = bus_tag;
  assign cdb_data  = bus_data;

  rs_station_unit dut_i (.*);

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int dst, input int sj, input int sk,
                       input bit uj, input bit uk, input int addr);
    @(negedge clk);
    iq_valid = 1; iq_op = 4'(op); iq_dst = RW'(dst); iq_src_j = RW'(sj);
    iq_src_k = RW'(sk); iq_use_j = uj; iq_use_k = uk; iq_addr = 16'(addr);
    @(negedge clk);
    iq_valid = 0;
  endtask

  task automatic take();
    @(negedge clk); ex_ready = 1;
    @(negedge clk); ex_ready = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) rf[r] = DW'(100 + r);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 iq_ready", iq_ready, 1);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 rf_wr_en", rf_wr_en, 0);
    chk("R1 bus_req", bus_req, 0);

    // I1: r1 <= f(r2, r3) into station tag 1, both sources from file
    issue(1, 1, 2, 3, 1, 1, 'h21);
    chk("R3 I1 offered", ex_valid, 1);
    chk("R2 I1 tag", ex_tag, 1);
    chk("R3 I1 vj", ex_vj, 102);
    chk("R3 I1 vk", ex_vk, 103);
    chk("R7 I1 op", ex_op, 1);
    chk("R7 I1 addr", ex_addr, 'h21);

    // I2: r4 <= f(r1, r5) waits on tag 1
    issue(2, 4, 1, 5, 1, 1, 0);
    chk("R7 I2 not offered", ex_tag, 1);
    // I3: r1 <= f(r6, r7), second writer of r1
    issue(3, 1, 6, 7, 1, 1, 0);
    chk("R8 oldest first", ex_tag, 1);
    take();
    chk("R8 next ready", ex_tag, 3);
    chk("R3 I3 vj", ex_vj, 106);

    // result of tag 1 waits for grant
    @(negedge clk);
    res_valid = 1; res_tag = 1; res_data = 500; #1;
    chk("R11 bus_req", bus_req, 1);
    chk("R11 no grant no accept", res_ready, 0);
    @(negedge clk);
    bus_grant = 1; #1;
    chk("R11 accepted on grant", res_ready, 1);
    chk("R9 r1 owner moved on", rf_wr_en, 0);
    @(negedge clk);
    res_valid = 0; bus_grant = 0;
    chk("R5 R8 I2 now oldest ready", ex_tag, 2);
    chk("R5 I2 captured vj", ex_vj, 500);
    chk("R3 I2 vk", ex_vk, 105);
    chk("R9 r1 unchanged", rf[1], 101);

    take();
    chk("R7 I3 after I2", ex_tag, 3);
    take();
    chk("R7 nothing ready", ex_valid, 0);

    // fill: I4 into tag 1, I5 (r1,r1 wait on tag 3) into tag 4
    issue(4, 8, 2, 3, 1, 1, 0);
    issue(5, 9, 1, 1, 1, 1, 0);
    chk("R2 full", iq_ready, 0);
    chk("R8 I4 offered", ex_tag, 1);
    // offered while full: must be dropped, r12 must stay unowned
    issue(7, 12, 0, 0, 0, 0, 0);
    chk("R2 still full", iq_ready, 0);

    // broadcast tag 3 -> writes r1, frees tag 3's station
    @(negedge clk);
    res_valid = 1; res_tag = 3; res_data = 777; bus_grant = 1; #1;
    chk("R9 write en", rf_wr_en, 1);
    chk("R9 write idx", rf_wr_idx, 1);
    chk("R9 write data", rf_wr_data, 777);
    @(negedge clk);
    res_valid = 0; bus_grant = 0;
    chk("R10 station freed", iq_ready, 1);
    chk("R8 I4 still oldest", ex_tag, 1);

    // same-cycle: I6 reads r4 while tag 2 broadcasts; k unused
    @(negedge clk);
    iq_valid = 1; iq_op = 6; iq_dst = 10; iq_src_j = 4; iq_src_k = 9;
    iq_use_j = 1; iq_use_k = 0;
    res_valid = 1; res_tag = 2; res_data = 321; bus_grant = 1; #1;
    chk("R9 r4 write", rf_wr_en, 1);
    chk("R9 r4 idx", rf_wr_idx, 4);
    @(negedge clk);
    iq_valid = 0; res_valid = 0; bus_grant = 0;

    chk("R8 I4 vj", ex_vj, 102);
    take();
    chk("R8 I5 next", ex_tag, 4);
    chk("R5 I5 vj", ex_vj, 777);
    chk("R5 I5 vk", ex_vk, 777);
    take();
    chk("R6 I6 offered", ex_tag, 3);
    chk("R6 I6 bypass vj", ex_vj, 321);
    chk("R3 I6 unused vk", ex_vk, 0);
    chk("R4 I6 op", ex_op, 6);
    take();
    chk("R7 all sent", ex_valid, 0);

    // I7 reads r12 (dropped offer left it unowned) and r4 (written)
    issue(8, 11, 12, 4, 1, 1, 0);
    chk("R2 lowest free station", ex_tag, 2);
    chk("R2 dropped offer ignored", ex_vj, 112);
    chk("R9 r4 in file", ex_vk, 321);

    // R4: r10 owned by tag 3 (I6); its broadcast writes r10
    @(negedge clk);
    res_valid = 1; res_tag = 3; res_data = 42; bus_grant = 1; #1;
    chk("R4 r10 owner", rf_wr_idx, 10);
    @(negedge clk);
    res_valid = 0; bus_grant = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule